// File: doc/BRIEF.md
# Parity-Protected Word Memory

A small synchronous memory, addressed by word, that keeps one check bit per word in a one-bit-wide array beside the data array. Both arrays share one address and one write enable. On a write, the check bit is computed from the incoming word under odd parity and stored in the same clock cycle. On a read, the returned word and its stored check bit are registered together, and a checker recounts the ones across both of them.

An even total means the word was corrupted. That result shows as an error flag that comes with the read data. It also sets a sticky interrupt request for the processor, and the address of the first failing read is kept for software to inspect. A test input can invert one chosen data bit while a write is stored, and the check bit is still computed from the clean word. This lets faults be planted on purpose.

Top module: `parity_mem`

## Requirements
- R1: After reset, `irq`, `rd_valid` and `rd_err` are 0 and `err_addr` is 0. Reset does not initialise memory contents.
- R2: A write stores `wr_data` at `addr` together with an odd-parity bit. The bit is 1 when `wr_data` holds an even number of ones. A later read of that address returns the word with `rd_err` = 0.
- R3: `rd_data` and `rd_valid` = 1 appear in the cycle after `rd_en` is sampled high. `rd_valid` is 0 in any cycle whose previous edge sampled `rd_en` low.
- R4: `rd_err` is 1 exactly when `rd_valid` is 1 and the ones in the returned word plus the stored bit add up to an even number.
- R5: A cycle with `rd_err` = 1 makes `irq` 1 from the following clock edge on.
- R6: `irq` stays 1 until an edge samples `irq_clr` high, after which it is 0. If `rd_err` is 1 in the same cycle as `irq_clr`, `irq` stays 1 (setting wins).
- R7: `err_addr` captures the address of the read that raised the first error since reset or the last clear. Later errors do not change it while `irq` remains set. An error that arrives together with `irq_clr` is captured.
- R8: With `inj_en` = 1 during a write, data bit `inj_sel` is stored inverted while the check bit comes from the uninverted `wr_data`. The next read of that address returns the flipped word with `rd_err` = 1.
- R9: A read and a write to the same address in one cycle return the contents held before that write.
- R10: A normal write over a corrupted word stores a fresh check bit, so the next read of it has `rd_err` = 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous reset, active low |
| addr | input | AW ($clog2(DEPTH)) | Word address for read and write |
| wr_en | input | 1 | Write the word and its check bit |
| wr_data | input | DW | Write data |
| rd_en | input | 1 | Read request |
| inj_en | input | 1 | Invert one stored data bit on this write |
| inj_sel | input | $clog2(DW) | Index of the bit to invert |
| irq_clr | input | 1 | Clears the sticky interrupt |
| rd_data | output | DW | Read data, one cycle after the request |
| rd_valid | output | 1 | Read data valid |
| rd_err | output | 1 | Parity mismatch on the current read |
| irq | output | 1 | Sticky error interrupt request |
| err_addr | output | AW | Address of the first failing read |

## Verification
A wrong check bit stored by a write shows up only when that address is read. One cycle after the request, it appears as `rd_err` high on data that matches what was written. One cycle after that, `irq` rises. A stale or wrongly captured error address stays invisible until an error occurs; after that it can be read on `err_addr` right away and persists until the interrupt is cleared. A fault in the set/clear priority of the interrupt is exposed only when a failing read and a clear coincide, so the bench drives that collision on purpose.

// File: rtl/parity_mem.sv
module parity_mem #(
  parameter int DW    = 8,
  parameter int DEPTH = 16,
  localparam int AW   = $clog2(DEPTH),
  localparam int SW   = $clog2(DW)
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic [AW-1:0] addr,
  input  logic          wr_en,
  input  logic [DW-1:0] wr_data,
  input  logic          rd_en,
  input  logic          inj_en,
  input  logic [SW-1:0] inj_sel,
  input  logic          irq_clr,
  output logic [DW-1:0] rd_data,
  output logic          rd_valid,
  output logic          rd_err,
  output logic          irq,
  output logic [AW-1:0] err_addr
);

  logic [DW-1:0] data_arr [DEPTH];
  logic          chk_arr  [DEPTH];
  logic          rd_chk;
  logic [AW-1:0] rd_addr_q;
  logic [DW-1:0] flip;

  assign flip = inj_en ? (DW'(1) << inj_sel) : '0;

  always_ff @(posedge clk) begin
    if (wr_en) begin
      data_arr[addr] <= wr_data ^ flip;
      chk_arr[addr]  <= ~^wr_data;
    end
    if (rd_en) begin
      rd_data   <= data_arr[addr];
      rd_chk    <= chk_arr[addr];
      rd_addr_q <= addr;
    end
  end

  assign rd_err = rd_valid & ~(^{rd_data, rd_chk});

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rd_valid <= 1'b0;
      irq      <= 1'b0;
      err_addr <= '0;
    end else begin
      rd_valid <= rd_en;
      if (rd_err && (!irq || irq_clr)) err_addr <= rd_addr_q;
      if (rd_err)       irq <= 1'b1;
      else if (irq_clr) irq <= 1'b0;
    end
  end

  AST_VALID_AFTER_REQ: assert property (@(posedge clk) disable iff (!rst_n) rd_en |=> rd_valid); // R3
  AST_NO_VALID_IDLE: assert property (@(posedge clk) disable iff (!rst_n) !rd_en |=> !rd_valid); // R3
  AST_ERR_RAISES_IRQ: assert property (@(posedge clk) disable iff (!rst_n) rd_err |=> irq); // R5
  AST_IRQ_STICKY: assert property (@(posedge clk) disable iff (!rst_n) (irq && !irq_clr) |=> irq); // R6
  AST_IRQ_CLEARS: assert property (@(posedge clk) disable iff (!rst_n) (irq_clr && !rd_err) |=> !irq); // R6
  AST_ADDR_HELD: assert property (@(posedge clk) disable iff (!rst_n) (irq && !irq_clr) |=> $stable(err_addr)); // R7

endmodule

// File: tb/test_parity_mem.sv
`timescale 1ns/1ps
module test_parity_mem;
  localparam int DW = 8;
  localparam int DEPTH = 16;
  localparam int AW = $clog2(DEPTH);
  localparam int SW = $clog2(DW);
  localparam int NV = 8;
  localparam logic [11:0] VEC [NV] = '{12'h000, 12'h1FF, 12'h201, 12'h380,
                                       12'h5A5, 12'h97F, 12'hE3C, 12'hF5A};

  logic clk = 0, rst_n = 0;
  logic [AW-1:0] addr = '0;
  logic wr_en = 0, rd_en = 0, inj_en = 0, irq_clr = 0;
  logic [DW-1:0] wr_data = '0;
  logic [SW-1:0] inj_sel = '0;
  logic [DW-1:0] rd_data;
  logic rd_valid, rd_err, irq;
  logic [AW-1:0] err_addr;
  int total = 0, bad = 0;

  always #2 clk = ~clk;

  parity_mem #(.DW(DW), .DEPTH(DEPTH)) i_parity_mem (
    .clk(clk), .rst_n(rst_n), .addr(addr), .wr_en(wr_en), .wr_data(wr_data),
    .rd_en(rd_en), .inj_en(inj_en), .inj_sel(inj_sel), .irq_clr(irq_clr),
    .rd_data(rd_data), .rd_valid(rd_valid), .rd_err(rd_err), .irq(irq),
    .err_addr(err_addr));

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s act=%0h exp=%0h", req, act, exp);
    end
  endtask

  task automatic wr(input logic [AW-1:0] a, input logic [DW-1:0] d,
                    input logic inj, input logic [SW-1:0] s);
    @(negedge clk);
    addr = a; wr_data = d; wr_en = 1; inj_en = inj; inj_sel = s;
    @(negedge clk);
    wr_en = 0; inj_en = 0;
  endtask

  task automatic rd(input logic [AW-1:0] a);
    @(negedge clk);
    addr = a; rd_en = 1;
    @(negedge clk);
    rd_en = 0;
  endtask

  initial begin
    repeat (20000) @(posedge clk);
    bad++;
    $display("FAIL watchdog act=hung exp=done");
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    chk("R1 irq", irq, 0); chk("R1 rd_valid", rd_valid, 0);
    chk("R1 rd_err", rd_err, 0); chk("R1 err_addr", err_addr, 0);
    rst_n = 1;

    for (int i = 0; i < NV; i++) wr(VEC[i][11:8], VEC[i][7:0], 0, '0);
    for (int i = 0; i < NV; i++) begin
      rd(VEC[i][11:8]);
      chk("R2 data", rd_data, VEC[i][7:0]);
      chk("R3 valid", rd_valid, 1);
      chk("R4 no err", rd_err, 0);
    end
    @(negedge clk);
    chk("R3 idle valid", rd_valid, 0);
    chk("R5 no irq", irq, 0);

    wr(4'd3, 8'h55, 1, 3'd2);
    rd(4'd3);
    chk("R8 flipped", rd_data, 8'h51);
    chk("R8 err", rd_err, 1);
    @(negedge clk);
    chk("R5 irq", irq, 1);
    chk("R7 addr", err_addr, 3);

    wr(4'd5, 8'hA5, 1, 3'd7);
    rd(4'd5);
    chk("R4 err", rd_err, 1);
    @(negedge clk);
    chk("R7 kept", err_addr, 3);
    chk("R6 held", irq, 1);

    @(negedge clk); irq_clr = 1;
    @(negedge clk); irq_clr = 0;
    chk("R6 cleared", irq, 0);

    wr(4'd3, 8'h55, 0, '0);
    rd(4'd3);
    chk("R10 data", rd_data, 8'h55);
    chk("R10 no err", rd_err, 0);

    rd(4'd5);
    chk("R4 err again", rd_err, 1);
    irq_clr = 1;
    @(negedge clk); irq_clr = 0;
    chk("R6 set wins", irq, 1);
    chk("R7 capture on clr", err_addr, 5);

    @(negedge clk);
    addr = 4'd0; wr_data = 8'h11; wr_en = 1; rd_en = 1;
    @(negedge clk);
    wr_en = 0; rd_en = 0;
    chk("R9 old data", rd_data, 8'h00);
    rd(4'd0);
    chk("R9 new data", rd_data, 8'h11);

    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule